// File: doc/BRIEF.md
# Sleep-Mode Entry and Recovery Sequencer

This block decides, cycle by cycle, whether a synchronous memory-style device is awake, going to sleep, asleep, or waking up. Its sleep request arrives on an asynchronous, active-high pin. The request passes through a flop synchroniser. Fixed-length windows are then counted from the synchronised edges. These windows set when the normal command inputs stop being honoured and when they are honoured again.

While asleep, the block holds the input gate closed and forces the data outputs to high impedance. Other circuitry uses these signals to freeze the core so that stored contents are kept. The sequencer also watches the command inputs during the two transition windows. If it sees an illegal command there, it raises a sticky violation flag. Two cases are illegal:
- any command that starts during entry;
- any write command during recovery.

An operation that is in flight when sleep begins is not protected. Flagging such an operation is the violation flag's purpose.

Top module: `snooze_seq`

## Requirements
- R1: After reset is released, `gate_o`, `out_hiz_o`, `asleep_o` and `violation_o` are all 0.
- R2: With default parameters, if `sleep_async_i` rises and stays high, `gate_o` and `asleep_o` go to 1 after the fifth rising clock edge. The five edges are two synchroniser stages, one edge to detect the request, and a two-cycle entry window.
- R3: With default parameters, if `sleep_async_i` falls while asleep, `asleep_o` drops after the third rising edge. `gate_o` drops after the fifth rising edge, once a two-cycle recovery window has run.
- R4: `out_hiz_o` is 1 exactly while `asleep_o` is 1.
- R5: `violation_o` is set by a command (`cmd_valid_i`=1, read or write) seen on any cycle of the entry window.
- R6: During the recovery window, a write command (`cmd_valid_i`=1 with `cmd_write_i`=1) sets `violation_o`. A read command (`cmd_write_i`=0) or no command does not set it.
- R7: Once set, `violation_o` stays at 1 until reset, whatever the inputs do.
- R8: Neither window can be aborted:
  - A request that drops during the entry window still leads to the sleep state, followed by a full recovery.
  - A request that returns during recovery is acted on only after recovery ends.
- R9: Commands seen while fully awake or fully asleep never set `violation_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sleep_async_i | input | 1 | Asynchronous active-high sleep request |
| cmd_valid_i | input | 1 | A command (read or write) starts this cycle |
| cmd_write_i | input | 1 | 1 = the command is a write, 0 = read |
| gate_o | output | 1 | 1 = ignore all normal inputs (asleep or recovering) |
| out_hiz_o | output | 1 | 1 = force data outputs to high impedance |
| asleep_o | output | 1 | 1 = in the sleep state |
| violation_o | output | 1 | Sticky flag for an illegal command in a transition window |

## Verification
The bench goes after four kinds of error:
- Exact latency of entry and exit. An extra or missing synchroniser stage, or an off-by-one window counter, shifts `gate_o` by one edge.
- Read versus write during recovery. A design that flagged every command, or none, would disagree on the read cases.
- Short sleep pulses that fall inside the entry window. A design that aborted the window would never assert `asleep_o`.
- The flag staying set across later clean traffic. A design that cleared it would lose a recorded fault.

Random sleep toggles and command traffic, with periodic resets, are compared on every cycle against a bench model.

// File: rtl/snooze_pkg.sv
package snooze_pkg;
  typedef enum logic [1:0] {
    SNZ_AWAKE   = 2'd0,
    SNZ_ENTRY   = 2'd1,
    SNZ_ASLEEP  = 2'd2,
    SNZ_RECOVER = 2'd3
  } snz_state_e;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/snz_window.sv
module snz_window #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST_VAL = W'(LEN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (!run_i)  cnt <= '0;
    else if (!last_o) cnt <= cnt + 1'b1;

  assign last_o = run_i && (cnt == LAST_VAL);

  // R8
  win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == '0));

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt <= LAST_VAL));
endmodule

// File: rtl/snooze_seq.sv
module snooze_seq
  import snooze_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_async_i,
  input  logic cmd_valid_i,
  input  logic cmd_write_i,
  output logic gate_o,
  output logic out_hiz_o,
  output logic asleep_o,
  output logic violation_o
);
  snz_state_e st, st_nx;
  logic sleep_s, entry_last, exit_last, in_entry, in_recov, bad_cmd;

  snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sleep_async_i), .q_o(sleep_s));

  assign in_entry = (st == SNZ_ENTRY);
  assign in_recov = (st == SNZ_RECOVER);

  snz_window #(.LEN(ENTRY_CYC)) u_entry_win (
    .clk(clk), .rst_n(rst_n), .run_i(in_entry), .last_o(entry_last));

  snz_window #(.LEN(EXIT_CYC)) u_exit_win (
    .clk(clk), .rst_n(rst_n), .run_i(in_recov), .last_o(exit_last));

  always_comb begin
    st_nx = st;
    unique case (st)
      SNZ_AWAKE:   if (sleep_s)    st_nx = SNZ_ENTRY;
      SNZ_ENTRY:   if (entry_last) st_nx = SNZ_ASLEEP;
      SNZ_ASLEEP:  if (!sleep_s)   st_nx = SNZ_RECOVER;
      SNZ_RECOVER: if (exit_last)  st_nx = SNZ_AWAKE;
      default:                     st_nx = SNZ_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= SNZ_AWAKE;
    else        st <= st_nx;

  assign bad_cmd = cmd_valid_i && (in_entry || (in_recov && cmd_write_i));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       violation_o <= 1'b0;
    else if (bad_cmd) violation_o <= 1'b1;

  assign asleep_o  = (st == SNZ_ASLEEP);
  assign out_hiz_o = asleep_o;
  assign gate_o    = asleep_o || in_recov;

  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o |=> violation_o);

  // R2
  enter_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> ($past(st) == SNZ_ENTRY));

  // R3
  gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> ($past(st) == SNZ_RECOVER));

  // R9
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation_o) |-> ($past(st) == SNZ_ENTRY || $past(st) == SNZ_RECOVER));
endmodule

// File: tb/snooze_seq_tb.sv
module snooze_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_async_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_write_i = 1'b0;
  logic gate_o, out_hiz_o, asleep_o, violation_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  snooze_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_async_i(sleep_async_i),
    .cmd_valid_i(cmd_valid_i), .cmd_write_i(cmd_write_i),
    .gate_o(gate_o), .out_hiz_o(out_hiz_o), .asleep_o(asleep_o),
    .violation_o(violation_o));

  // Reference model, written from the requirements: phase 0 awake,
  // 1 entry window, 2 asleep, 3 recovery window; each window lasts two cycles.
  logic m_s1, m_s2, m_viol;
  int   m_ph, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_viol <= 0; m_ph <= 0; m_cnt <= 0;
    end else begin
      m_s1 <= sleep_async_i;
      m_s2 <= m_s1;
      if (cmd_valid_i && (m_ph == 1 || (m_ph == 3 && cmd_write_i))) m_viol <= 1;
      case (m_ph)
        0: if (m_s2) begin m_ph <= 1; m_cnt <= 0; end
        1: if (m_cnt == 1) m_ph <= 2; else m_cnt <= m_cnt + 1;
        2: if (!m_s2) begin m_ph <= 3; m_cnt <= 0; end
        default: if (m_cnt == 1) m_ph <= 0; else m_cnt <= m_cnt + 1;
      endcase
    end
  end

  function automatic logic exp_gate(int ph);
    return (ph == 2) || (ph == 3);
  endfunction

  function automatic logic exp_asleep(int ph);
    return ph == 2;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(gate_o,      exp_gate(m_ph),   "R2 R3 gate_o");
      check(asleep_o,    exp_asleep(m_ph), "R2 R3 asleep_o");
      check(out_hiz_o,   exp_asleep(m_ph), "R4 out_hiz_o");
      check(violation_o, m_viol,           "R5 R6 R7 R9 violation_o");
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sleep_async_i = 0; cmd_valid_i = 0; cmd_write_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    cmp_en = 1;
    // R1 reset state
    check(gate_o, 1'b0, "R1 gate_o"); check(out_hiz_o, 1'b0, "R1 out_hiz_o");
    check(asleep_o, 1'b0, "R1 asleep_o"); check(violation_o, 1'b0, "R1 violation_o");

    // R2 entry latency: set at a negedge, gate_o still low after 4 edges, high after 5
    sleep_async_i = 1; cyc(4);
    check(gate_o, 1'b0, "R2 gate before 5th edge");
    cyc(1);
    check(gate_o, 1'b1, "R2 gate at 5th edge"); check(asleep_o, 1'b1, "R2 asleep");
    // R9 commands while asleep do not flag
    cmd_valid_i = 1; cmd_write_i = 1; cyc(3); cmd_valid_i = 0;
    check(violation_o, 1'b0, "R9 asleep commands");
    // R3 exit latency, with reads during recovery (R6 legal case)
    sleep_async_i = 0; cyc(3);
    check(asleep_o, 1'b0, "R3 asleep drops at 3rd edge");
    check(gate_o, 1'b1, "R3 gate held in recovery");
    cmd_valid_i = 1; cmd_write_i = 0; cyc(2); cmd_valid_i = 0;
    check(gate_o, 1'b0, "R3 gate drops at 5th edge");
    check(violation_o, 1'b0, "R6 read in recovery legal");
    // R9 awake traffic
    cmd_valid_i = 1; cmd_write_i = 1; cyc(4); cmd_valid_i = 0;
    check(violation_o, 1'b0, "R9 awake commands");

    // R6 write in recovery flags; R7 stays set
    sleep_async_i = 1; cyc(8); sleep_async_i = 0; cyc(3);
    cmd_valid_i = 1; cmd_write_i = 1; cyc(1); cmd_valid_i = 0; cyc(1);
    check(violation_o, 1'b1, "R6 write in recovery");
    cyc(20);
    check(violation_o, 1'b1, "R7 sticky");

    // R5 read in entry window flags
    do_reset();
    sleep_async_i = 1; cyc(3);
    cmd_valid_i = 1; cmd_write_i = 0; cyc(1); cmd_valid_i = 0; cyc(1);
    check(violation_o, 1'b1, "R5 read in entry");
    sleep_async_i = 0; cyc(10);

    // R8 short pulse still yields a full sleep/recovery sequence
    do_reset();
    sleep_async_i = 1; cyc(1); sleep_async_i = 0; cyc(4);
    check(asleep_o, 1'b1, "R8 short pulse sleeps");
    cyc(3);
    check(gate_o, 1'b0, "R8 recovered after pulse");
    check(asleep_o, 1'b0, "R8 not asleep after pulse");

    // Random traffic with periodic resets
    for (int blk = 0; blk < 15; blk++) begin
      do_reset();
      for (int i = 0; i < 200; i++) begin
        if (($urandom % 12) == 0) sleep_async_i = ~sleep_async_i;
        cmd_valid_i = (($urandom % 4) == 0);
        cmd_write_i = $urandom % 2;
        cyc(1);
      end
    end
    cmd_valid_i = 0;
    cyc(2);
    cmp_en = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule